// File: doc/BRIEF.md
# Dual-Control Dual-Modulus Prescaler

This block divides a fast oscillator clock by one of four ratios for the feedback path of a phase-locked synthesizer. Two static control inputs pick the ratio. `rangeSel` chooses between a short range and a long range. `modSel` chooses between the base ratio of that range and the base ratio plus one. The two inputs use opposite senses: a high level on `rangeSel` picks the short range, while a high level on `modSel` drops the extra count. The divided clock leaves on `divOut`. A phase detector or an external counter can take it from there.

The divider is a counter clocked by the oscillator, with a registered output. Ratio changes take effect only at the boundary between two output periods, so a period is never cut short or stretched partway through. A synthesizer-enable input parks the divider in an idle state with its output held low. When the enable returns, a fresh period starts at once.

Top module: `dual_ratio_prescaler`

## Requirements
- R1: With `rangeSel`=1 and `modSel`=1, each output period lasts 64 input clock cycles.
- R2: With `rangeSel`=1 and `modSel`=0, each output period lasts 65 input clock cycles.
- R3: With `rangeSel`=0 and `modSel`=1, each output period lasts 128 input clock cycles.
- R4: With `rangeSel`=0 and `modSel`=0, each output period lasts 129 input clock cycles.
- R5: In each period of N cycles, `divOut` is high for the first floor(N/2) cycles and low for the remaining cycles. A period begins with `divOut` rising.
- R6: The control inputs are sampled only at the clock edge that starts a new period. A change during a period leaves that period's length and high time unchanged, and the next period uses the new ratio.
- R7: After a clock edge with `synthEn` low, `divOut` is low, and it stays low while `synthEn` stays low. At the first edge with `synthEn` high, `divOut` goes high and a full period begins with the ratio selected at that edge.
- R8: A clock edge with `rstN` low drives `divOut` low and clears the count, whatever the state of `synthEn`. The first enabled edge after reset starts a full period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock being divided |
| rstN | input | 1 | Synchronous active-low reset |
| synthEn | input | 1 | Divider enable; low holds the output idle and low |
| rangeSel | input | 1 | 1 selects the 64/65 range, 0 selects the 128/129 range |
| modSel | input | 1 | 1 selects the base ratio, 0 selects base plus one |
| divOut | output | 1 | Divided clock, registered |

## Verification
Two things can land on the same edge: the end of a period, where the ratio reloads, and a change on a control input or on `synthEn`. The bench provokes this by moving the controls on random cycles. Some of these fall just before the terminal count, some in the middle of the high phase and some in the low phase. It also drops and raises the enable at arbitrary points. Each case is judged two ways: a cycle-by-cycle comparison against a bench model built from the requirements, and direct measurement of period length and high time. The measurement shows whether the period already running kept its ratio and whether the next one took the new selection.

// File: rtl/divider_pkg.sv
`timescale 1ns/1ps
package divider_pkg;
  // One-hot strobes passed from the control section to the counting datapath.
  typedef struct packed {
    logic idle;     // hold count at zero, output low
    logic restart;  // begin a new period: count to zero, output high
    logic advance;  // step the count within the running period
  } divStrobe_t;
endpackage

// File: rtl/div_ctrl.sv
`timescale 1ns/1ps
module div_ctrl
  import divider_pkg::*;
#(
  parameter int LOW_LOG2 = 6,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             synthEn,
  input  logic             rangeSel,
  input  logic             modSel,
  input  logic             termHit,
  output divStrobe_t       strobe,
  output logic [CNT_W-1:0] ratio
);
  localparam int LOW_BASE  = 1 << LOW_LOG2;
  localparam int HIGH_BASE = LOW_BASE * 2;

  logic             runQ;
  logic [CNT_W-1:0] ratioQ;
  logic [CNT_W-1:0] pinBase;
  logic [CNT_W-1:0] pinRatio;

  // Range pin high picks the short range; modulus pin low adds one count.
  always_comb begin
    pinBase  = rangeSel ? CNT_W'(LOW_BASE) : CNT_W'(HIGH_BASE);
    pinRatio = pinBase + (modSel ? CNT_W'(0) : CNT_W'(1));
  end

  always_comb begin
    strobe.idle    = !rstN || !synthEn;
    strobe.restart = !strobe.idle && (!runQ || termHit);
    strobe.advance = !strobe.idle && !strobe.restart;
  end

  always_ff @(posedge clk) begin
    runQ <= !strobe.idle;
    if (strobe.idle || strobe.restart) begin
      ratioQ <= pinRatio;
    end
  end

  assign ratio = ratioQ;

  // R6: the ratio may only move at a period boundary or while idle
  assert_ratio_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> $stable(ratio))
    else $error("ratio changed inside a period");
endmodule

// File: rtl/div_path.sv
`timescale 1ns/1ps
module div_path
  import divider_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  divStrobe_t       strobe,
  input  logic [CNT_W-1:0] ratio,
  output logic             termHit,
  output logic             divOut
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] halfCnt;

  always_comb begin
    halfCnt = ratio >> 1;
    cntNext = cnt + CNT_W'(1);
    termHit = (cnt == ratio - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (strobe.idle) begin
      cnt    <= '0;
      divOut <= 1'b0;
    end else if (strobe.restart) begin
      cnt    <= '0;
      divOut <= 1'b1;
    end else begin
      cnt    <= cntNext;
      divOut <= (cntNext < halfCnt);
    end
  end

  // R5: the count never leaves the range of the ratio in force
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (strobe.idle)
    cnt < ratio)
    else $error("count outside ratio");

  // R5: a period opens with the output rising at count zero
  assert_rise_at_start_R5: assert property (@(posedge clk) disable iff (strobe.idle)
    $rose(divOut) |-> (cnt == '0))
    else $error("rise away from period start");

  // R5: within a running period the output falls exactly at half the ratio
  assert_fall_at_half_R5: assert property (@(posedge clk) disable iff (strobe.idle)
    ($fell(divOut) && $past(strobe.advance)) |-> (cnt == (ratio >> 1)))
    else $error("fall away from half ratio");
endmodule

// File: rtl/dual_ratio_prescaler.sv
`timescale 1ns/1ps
module dual_ratio_prescaler
  import divider_pkg::*;
#(
  parameter int LOW_LOG2 = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic synthEn,
  input  logic rangeSel,
  input  logic modSel,
  output logic divOut
);
  localparam int LOW_BASE = 1 << LOW_LOG2;
  localparam int CNT_W    = $clog2(2 * LOW_BASE + 2);

  divStrobe_t       strobe;
  logic [CNT_W-1:0] ratio;
  logic             termHit;

  div_ctrl #(.LOW_LOG2(LOW_LOG2), .CNT_W(CNT_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .synthEn  (synthEn),
    .rangeSel (rangeSel),
    .modSel   (modSel),
    .termHit  (termHit),
    .strobe   (strobe),
    .ratio    (ratio)
  );

  div_path #(.CNT_W(CNT_W)) uPath (
    .clk     (clk),
    .strobe  (strobe),
    .ratio   (ratio),
    .termHit (termHit),
    .divOut  (divOut)
  );

  // R7: a disabled edge leaves the output low
  assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    !synthEn |=> !divOut)
    else $error("output active while disabled");
endmodule

// File: tb/tb_dual_ratio_prescaler.sv
`timescale 1ns/1ps
module tb_dual_ratio_prescaler;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic synthEn = 1'b0;
  logic rangeSel = 1'b1;
  logic modSel = 1'b1;
  logic divOut;

  int checks = 0;
  int failures = 0;
  bit cmpOn = 1'b0;
  string curTag = "R5";

  // bench model state
  bit mRun = 1'b0;
  int mPos = 0;
  int mN = 64;
  bit mOut = 1'b0;

  always #10 clk = ~clk;

  dual_ratio_prescaler dut (
    .clk(clk), .rstN(rstN), .synthEn(synthEn),
    .rangeSel(rangeSel), .modSel(modSel), .divOut(divOut)
  );

  function automatic int expRatio(input logic rs, input logic ms);
    int base;
    base = rs ? 64 : 128;
    return ms ? base : base + 1;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model built from the requirements
  always @(posedge clk) begin
    if (!rstN || !synthEn) begin
      mRun = 1'b0; mPos = 0; mOut = 1'b0;
    end else if (!mRun || mPos == mN - 1) begin
      mN = expRatio(rangeSel, modSel); mPos = 0; mRun = 1'b1; mOut = 1'b1;
    end else begin
      mPos++; mOut = (mPos < mN / 2);
    end
  end

  always @(negedge clk) begin
    if (cmpOn) check(divOut === mOut, curTag, int'(divOut), int'(mOut));
  end

  task automatic setCtrl(input logic rs, input logic ms);
    @(negedge clk);
    rangeSel = rs; modSel = ms;
  endtask

  task automatic waitRise();
    logic p;
    p = divOut;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (divOut && !p) return;
      p = divOut;
    end
  endtask

  // count length and high time of one period starting at a rise
  task automatic measure(input int expN, input string tag);
    int hi; int len; logic p;
    waitRise();
    hi = 1; len = 1; p = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (divOut && !p) break;
      if (divOut) hi++;
      len++;
      p = divOut;
    end
    check(len == expN, {tag, " period"}, len, expN);
    check(hi == expN / 2, {tag, " high time R5"}, hi, expN / 2);
  endtask

  task automatic midChange(input logic ars, input logic ams, input logic brs,
                           input logic bms, input int k);
    int len; logic p;
    setCtrl(ars, ams);
    waitRise(); waitRise();
    len = 1;
    for (int i = 0; i < k; i++) begin @(negedge clk); len++; end
    rangeSel = brs; modSel = bms;
    p = divOut;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (divOut && !p) break;
      len++;
      p = divOut;
    end
    check(len == expRatio(ars, ams), "R6 running period kept", len, expRatio(ars, ams));
    measure(expRatio(brs, bms), "R6 next period");
  endtask

  initial begin
    void'($urandom(32'd2718));
    // R8: reset state
    repeat (3) @(negedge clk);
    check(divOut == 1'b0, "R8 reset output", int'(divOut), 0);
    cmpOn = 1'b1;
    synthEn = 1'b1;
    @(negedge clk);
    check(divOut == 1'b0, "R8 held in reset while enabled", int'(divOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(divOut == 1'b1, "R8 first enabled edge starts period", int'(divOut), 1);

    // R1..R4: all four selections
    curTag = "R1"; setCtrl(1'b1, 1'b1); measure(64, "R1"); measure(64, "R1");
    curTag = "R2"; setCtrl(1'b1, 1'b0); measure(65, "R2"); measure(65, "R2");
    curTag = "R3"; setCtrl(1'b0, 1'b1); measure(128, "R3"); measure(128, "R3");
    curTag = "R4"; setCtrl(1'b0, 1'b0); measure(129, "R4"); measure(129, "R4");

    // R6: changes inside a period, in the high phase, low phase and at the last cycle
    curTag = "R6";
    midChange(1'b1, 1'b1, 1'b0, 1'b0, 10);
    midChange(1'b0, 1'b0, 1'b1, 1'b0, 100);
    midChange(1'b1, 1'b0, 1'b0, 1'b1, 63);
    midChange(1'b0, 1'b1, 1'b1, 1'b1, 127);

    // R7: enable drop mid-high, hold, and restart with a new ratio
    curTag = "R7";
    setCtrl(1'b0, 1'b0);
    waitRise();
    repeat (5) @(negedge clk);
    synthEn = 1'b0;
    @(negedge clk);
    check(divOut == 1'b0, "R7 low after disable", int'(divOut), 0);
    rangeSel = 1'b1; modSel = 1'b0;
    repeat (20) @(negedge clk);
    check(divOut == 1'b0, "R7 still low while disabled", int'(divOut), 0);
    synthEn = 1'b1;
    @(negedge clk);
    check(divOut == 1'b1, "R7 restart high", int'(divOut), 1);
    measure(65, "R7 after restart");

    // R8: reset in the middle of a run
    curTag = "R8";
    waitRise();
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(divOut == 1'b0, "R8 mid-run reset", int'(divOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(divOut == 1'b1, "R8 restart after reset", int'(divOut), 1);

    // random mix: controls and enable moving at arbitrary cycles (R5, R6, R7)
    curTag = "R6 random";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 40) == 0) begin
        rangeSel = 1'($urandom_range(0, 1));
        modSel   = 1'($urandom_range(0, 1));
      end
      if ($urandom_range(0, 300) == 0) synthEn = ~synthEn;
      else if (!synthEn && $urandom_range(0, 8) == 0) synthEn = 1'b1;
    end

    cmpOn = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule